// File: doc/BRIEF.md
# Buffered SPI Master Byte Engine

This block is a full-duplex SPI master that moves one byte at a time. A byte written to the data port waits in a one-byte transmit holding register. One system clock later it moves into the shift register and goes out on MOSI, most significant bit first. While the byte goes out, MISO is shifted in. The completed byte lands in a one-byte receive holding register, which the host reads back through the same data port. To read a byte from the slave without sending real data, the host writes a dummy byte.

The host enables the engine and selects the serial clock rate with a divider value. It drives the slave-select line itself; the engine never touches it. If a second byte is queued while the first is still shifting, the engine streams both with no idle gap. MISO can be sampled in the middle of each bit or, to tolerate the round-trip delay of a fast link, at the end of the bit. Four status flags can each raise the interrupt line through their own enable bit: transmit-empty, receive-full, receive-overflow and byte-done. The busy flag cannot raise the interrupt.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, tx_empty=1, rx_full=0, rx_ovf=0, byte_done=0, busy=0, sclk=0, irq=0 and ss_n=1.
- R2: With divider value N, sclk idles low and has a period of 2*(N+1) system clocks. It is high for 8*(N+1) clocks of a byte, and a byte keeps busy high for exactly 16*(N+1) clocks.
- R3: While enable is 0 no transfer starts. Dropping enable in the middle of a byte clears busy and returns sclk low on the next clock, and it leaves a queued transmit byte in place (tx_empty stays 0).
- R4: A data write drops tx_empty on the next clock. One clock later the byte enters the shift register, tx_empty returns to 1 and busy goes to 1.
- R5: Bits leave MSB first. MOSI changes only together with the falling edge of sclk, so the slave sees each bit stable at the rising edge.
- R6: With sample_end=0, MISO is sampled at the rising edge of sclk, in the middle of the bit.
- R7: With sample_end=1, MISO is sampled at the falling edge of sclk, at the end of the bit.
- R8: When a byte completes and the receive register is empty, the byte is stored, rx_full goes to 1 and rd_data shows it. Pulsing rd_en clears rx_full on the next clock.
- R9: If a byte completes while rx_full=1 and rd_en is 0 in that cycle, the new byte is dropped, rd_data keeps the old byte and rx_ovf goes to 1. rx_ovf stays set until an ovf_clr pulse.
- R10: If a byte is queued when the current byte ends, the next byte starts in the same clock and busy stays high with no gap.
- R11: A clr_tx pulse empties the transmit holding register (tx_empty=1), so nothing is sent when the engine is next enabled.
- R12: irq = OR of the flags gated by irq_en, where irq_en bit 0 = tx_empty, bit 1 = rx_full, bit 2 = rx_ovf and bit 3 = byte_done. busy never drives irq.
- R13: ss_n copies ss_ctl one clock later and is never changed by the engine.
- R14: byte_done is set when a byte completes and stays set until a done_clr pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Engine enable |
| clk_div | input | DIVW | Divider value N; sclk period is 2*(N+1) clocks |
| sample_end | input | 1 | 0: sample MISO mid-bit, 1: sample at end of bit |
| ss_ctl | input | 1 | Host-controlled slave-select level |
| wr_en | input | 1 | Write strobe for the data port |
| wr_data | input | DW | Byte to transmit |
| rd_en | input | 1 | Read strobe for the data port, clears rx_full |
| rd_data | output | DW | Received byte held in the receive register |
| clr_tx | input | 1 | Write-one flush of the transmit holding register |
| ovf_clr | input | 1 | Write-one clear of rx_ovf |
| done_clr | input | 1 | Write-one clear of byte_done |
| irq_en | input | 4 | Interrupt enables for the four flags |
| tx_empty | output | 1 | Transmit holding register empty |
| rx_full | output | 1 | Receive holding register holds an unread byte |
| rx_ovf | output | 1 | A received byte was dropped |
| byte_done | output | 1 | Sticky end-of-byte flag |
| busy | output | 1 | A byte is shifting |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Slave select, registered from ss_ctl |

## Verification
The transmit flags move one clock after a write: tx_empty falls on the next clock and the load happens one clock later. The bench samples on the falling clock edge after each of those two rising edges. Completion flags and received data appear on the same clock on which busy falls, so the bench counts busy-high cycles until the first low sample and checks the count against 16*(N+1). At that same sample it reads rx_full, byte_done and rd_data. A slave model in the bench drives MISO either at the falling or at the rising sclk edge, so the expected bytes for mid-bit and end-of-bit sampling are derived apart from the design.

// File: rtl/spi_bm_pkg.sv
// Shared constants for the SPI byte master: flag bit positions in the
// interrupt enable / status vector.
package spi_bm_pkg;
    localparam int NFLAGS  = 4;
    localparam int FI_TXE  = 0;  // transmit holding register empty
    localparam int FI_RXF  = 1;  // receive holding register full
    localparam int FI_OVF  = 2;  // receive overflow
    localparam int FI_DONE = 3;  // byte completed
endpackage

// File: rtl/spi_clk_div.sv
// Half-period tick generator. While run is high, it pulses tick once every
// div+1 system clocks. Assumes div may change at any time; the new value
// takes effect at the next compare.
module spi_clk_div #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    assign tick = run && (cnt >= div);

    // Count system clocks within a half period, restart when idle or on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R2
endmodule

// File: rtl/spi_shift_core.sv
// Shift engine: generates sclk (idle low), drives MOSI MSB first on the
// falling phase and captures MISO either at the rising edge (mid-bit) or at
// the falling edge (end of bit). done is a combinational pulse in the cycle
// the last falling edge is taken; rx_word is valid with it.
// Assumes load is only raised when enable is high.
module spi_shift_core #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          tick,
    input  logic          sample_end,
    input  logic          miso,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic          busy,
    output logic          sclk,
    output logic          mosi,
    output logic          done,
    output logic [DW-1:0] rx_word
);
    localparam int BCW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

    logic [BCW-1:0] bitcnt;
    logic [DW-1:0]  tx_sr;
    logic [DW-1:0]  rx_sr;
    logic           mid_bit;
    logic           rx_bit;
    logic           bit_last;

    assign bit_last = (bitcnt == LAST_BIT);
    assign rx_bit   = sample_end ? miso : mid_bit;
    assign rx_word  = {rx_sr[DW-2:0], rx_bit};
    assign done     = busy && enable && tick && sclk && bit_last;
    assign mosi     = busy && tx_sr[DW-1];

    // Sequence the two half periods of each bit and the bit count of a byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sclk    <= 1'b0;
            bitcnt  <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            mid_bit <= 1'b0;
        end else if (!enable) begin
            busy   <= 1'b0;
            sclk   <= 1'b0;
            bitcnt <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            sclk   <= 1'b0;
            bitcnt <= '0;
            tx_sr  <= load_data;
        end else if (busy && tick) begin
            if (!sclk) begin
                sclk    <= 1'b1;
                mid_bit <= miso;
            end else begin
                sclk  <= 1'b0;
                tx_sr <= {tx_sr[DW-2:0], 1'b0};
                rx_sr <= {rx_sr[DW-2:0], rx_bit};
                if (bit_last) begin
                    busy <= 1'b0;
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                end
            end
        end
    end

    AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick && !load) |=> $stable(sclk)); // R2
    AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !sclk)); // R3
    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && load) |=> busy); // R10
    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && !(tick && sclk)) |=> $stable(mosi)); // R5
endmodule

// File: rtl/spi_buf_status.sv
// Holding registers and flags: one-byte transmit buffer, one-byte receive
// buffer with overflow detection, sticky done flag and masked interrupt.
// Assumes load and done come from the shift engine in the same cycle the
// engine takes the byte or finishes it.
module spi_buf_status
    import spi_bm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_en,
    input  logic              clr_tx,
    input  logic              ovf_clr,
    input  logic              done_clr,
    input  logic              load,
    input  logic              done,
    input  logic [DW-1:0]     rx_word,
    input  logic [NFLAGS-1:0] irq_en,
    output logic              tx_full,
    output logic [DW-1:0]     tx_data,
    output logic [DW-1:0]     rx_data,
    output logic [NFLAGS-1:0] flags,
    output logic              irq
);
    logic rx_full;
    logic rx_ovf;
    logic done_f;

    // Transmit holding register: flush wins, then a write, then the load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_full <= 1'b0;
            tx_data <= '0;
        end else if (clr_tx) begin
            tx_full <= 1'b0;
        end else if (wr_en) begin
            tx_full <= 1'b1;
            tx_data <= wr_data;
        end else if (load) begin
            tx_full <= 1'b0;
        end
    end

    // Receive holding register: accept when empty or read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
            rx_data <= '0;
        end else if (done && (!rx_full || rd_en)) begin
            rx_full <= 1'b1;
            rx_data <= rx_word;
        end else if (rd_en) begin
            rx_full <= 1'b0;
        end
    end

    // Overflow flag: set on a dropped byte, write-one clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ovf <= 1'b0;
        end else if (done && rx_full && !rd_en) begin
            rx_ovf <= 1'b1;
        end else if (ovf_clr) begin
            rx_ovf <= 1'b0;
        end
    end

    // Byte-done flag: set at the end of every byte, write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_f <= 1'b0;
        end else if (done) begin
            done_f <= 1'b1;
        end else if (done_clr) begin
            done_f <= 1'b0;
        end
    end

    always_comb begin
        flags          = '0;
        flags[FI_TXE]  = !tx_full;
        flags[FI_RXF]  = rx_full;
        flags[FI_OVF]  = rx_ovf;
        flags[FI_DONE] = done_f;
    end

    assign irq = |(flags & irq_en);

    AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_en) |=> !tx_full); // R4
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_en) |=> $stable(rx_data)); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf && !ovf_clr) |=> rx_ovf); // R9
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_f && !done_clr) |=> done_f); // R14
    AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_full); // R8
endmodule

// File: rtl/spi_byte_master.sv
// Top of the buffered SPI master byte engine. Joins the divider, the shift
// engine and the buffer/flag logic, decides when a queued byte is loaded and
// registers the host-driven slave select. Assumes all inputs are synchronous
// to clk.
module spi_byte_master
    import spi_bm_pkg::*;
#(
    parameter int DW   = 8,
    parameter int DIVW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIVW-1:0]   clk_div,
    input  logic              sample_end,
    input  logic              ss_ctl,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_en,
    output logic [DW-1:0]     rd_data,
    input  logic              clr_tx,
    input  logic              ovf_clr,
    input  logic              done_clr,
    input  logic [NFLAGS-1:0] irq_en,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              rx_ovf,
    output logic              byte_done,
    output logic              busy,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);
    logic              tick;
    logic              load;
    logic              done;
    logic              tx_full;
    logic [DW-1:0]     tx_data;
    logic [DW-1:0]     rx_word;
    logic [NFLAGS-1:0] flags;

    // A queued byte starts when idle or exactly at the end of the current one.
    assign load = enable && tx_full && (!busy || done);

    spi_clk_div #(.DIVW(DIVW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy && enable),
        .div   (clk_div),
        .tick  (tick)
    );

    spi_shift_core #(.DW(DW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tick       (tick),
        .sample_end (sample_end),
        .miso       (miso),
        .load       (load),
        .load_data  (tx_data),
        .busy       (busy),
        .sclk       (sclk),
        .mosi       (mosi),
        .done       (done),
        .rx_word    (rx_word)
    );

    spi_buf_status #(.DW(DW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .clr_tx   (clr_tx),
        .ovf_clr  (ovf_clr),
        .done_clr (done_clr),
        .load     (load),
        .done     (done),
        .rx_word  (rx_word),
        .irq_en   (irq_en),
        .tx_full  (tx_full),
        .tx_data  (tx_data),
        .rx_data  (rd_data),
        .flags    (flags),
        .irq      (irq)
    );

    assign tx_empty  = flags[FI_TXE];
    assign rx_full   = flags[FI_RXF];
    assign rx_ovf    = flags[FI_OVF];
    assign byte_done = flags[FI_DONE];

    // Slave select is a plain register of the host-driven level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_n <= 1'b1;
        end else begin
            ss_n <= ss_ctl;
        end
    end

    AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(enable)); // R3
    AST_BUSY_NOT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq); // R12
endmodule

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;
    localparam int CLK_P = 10;
    localparam int NV    = 7;

    typedef struct packed {
        logic [7:0] div;
        logic       samp;
        logic       late;
        logic       init;
        logic [7:0] tx;
        logic [7:0] sb;
        logic [7:0] exp;
    } vec_t;

    // late slave + mid sample: expected = {init, sb[7:1]}; otherwise sb.
    localparam vec_t VECS [NV] = '{
        '{8'd1, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 8'h3C},
        '{8'd0, 1'b0, 1'b0, 1'b0, 8'h5A, 8'hC3, 8'hC3},
        '{8'd2, 1'b1, 1'b0, 1'b0, 8'h81, 8'h7E, 8'h7E},
        '{8'd1, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h96, 8'h96},
        '{8'd1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h96, 8'hCB},
        '{8'd3, 1'b0, 1'b1, 1'b0, 8'h6B, 8'hE1, 8'h70},
        '{8'd0, 1'b1, 1'b1, 1'b0, 8'hC7, 8'h5D, 8'h5D}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] clk_div = 8'd1;
    logic       sample_end = 1'b0;
    logic       ss_ctl = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       clr_tx = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       done_clr = 1'b0;
    logic [3:0] irq_en = 4'h0;
    logic       tx_empty, rx_full, rx_ovf, byte_done, busy, irq, sclk, mosi, ss_n;
    logic       miso = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic        late_m = 1'b0;
    logic [15:0] slv_sr = '0;
    logic [15:0] mcap = '0;

    spi_byte_master u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clk_div(clk_div),
        .sample_end(sample_end), .ss_ctl(ss_ctl), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .clr_tx(clr_tx),
        .ovf_clr(ovf_clr), .done_clr(done_clr), .irq_en(irq_en),
        .tx_empty(tx_empty), .rx_full(rx_full), .rx_ovf(rx_ovf),
        .byte_done(byte_done), .busy(busy), .irq(irq), .sclk(sclk),
        .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    always #(CLK_P/2) clk = ~clk;

    // Slave model: captures MOSI on sclk rise; drives MISO on fall (normal)
    // or on rise (late, emulating round-trip delay).
    always @(posedge sclk) begin
        mcap <= {mcap[14:0], mosi};
        if (late_m) begin
            miso   <= slv_sr[15];
            slv_sr <= {slv_sr[14:0], 1'b0};
        end
    end
    always @(negedge sclk) begin
        if (!late_m) begin
            miso   <= slv_sr[14];
            slv_sr <= {slv_sr[14:0], 1'b0};
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not end, got %0d cycles exp < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic ncyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic preload(input logic [7:0] sb, input logic late, input logic init);
        late_m = late;
        slv_sr = {sb, 8'h00};
        miso   = late ? init : sb[7];
        mcap   = '0;
    endtask

    task automatic run_vec(input vec_t v);
        int cyc;
        int hi;
        clk_div    = v.div;
        sample_end = v.samp;
        preload(v.sb, v.late, v.init);
        wr_en = 1'b1; wr_data = v.tx;
        @(negedge clk);
        wr_en = 1'b0;
        chk(tx_empty == 1'b0, "R4 tx_empty after write", 32'(tx_empty), 0);
        @(negedge clk);
        chk(tx_empty && busy, "R4 load next clock", {tx_empty, busy}, 2'b11);
        cyc = 0; hi = 0;
        while (busy && cyc < 10000) begin
            cyc++;
            if (sclk) hi++;
            @(negedge clk);
        end
        chk(cyc == 16 * (int'(v.div) + 1), "R2 byte duration", cyc, 16 * (int'(v.div) + 1));
        chk(hi == 8 * (int'(v.div) + 1), "R2 sclk high time", hi, 8 * (int'(v.div) + 1));
        chk(sclk == 1'b0, "R2 sclk idle low", 32'(sclk), 0);
        chk(mcap[7:0] == v.tx, "R5 MSB-first MOSI", mcap[7:0], v.tx);
        chk(rd_data == v.exp, v.samp ? "R7 end-of-bit sample" : "R6 mid-bit sample",
            rd_data, v.exp);
        chk(rx_full && byte_done, "R8 R14 flags at byte end", {rx_full, byte_done}, 2'b11);
        rd_en = 1'b1; done_clr = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; done_clr = 1'b0;
        chk(!rx_full && !byte_done, "R8 R14 read and done clear", {rx_full, byte_done}, 0);
    endtask

    initial begin
        ncyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({tx_empty, rx_full, rx_ovf, byte_done, busy, sclk, irq, ss_n} == 8'b1000_0001,
            "R1 reset state", {tx_empty, rx_full, rx_ovf, byte_done, busy, sclk, irq, ss_n},
            8'b1000_0001);

        // R13: slave select follows host level one clock later
        ss_ctl = 1'b0;
        @(negedge clk);
        chk(ss_n == 1'b0, "R13 ss_n follows", 32'(ss_n), 0);

        // Vector table
        enable = 1'b1;
        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R3 / R11: no transfer while disabled, then flush the queued byte
        enable = 1'b0;
        wr_en = 1'b1; wr_data = 8'h33;
        @(negedge clk);
        wr_en = 1'b0;
        ncyc(40);
        chk(!busy && !sclk && !tx_empty, "R3 disabled holds byte", {busy, sclk, tx_empty}, 0);
        clr_tx = 1'b1;
        @(negedge clk);
        clr_tx = 1'b0;
        chk(tx_empty == 1'b1, "R11 flush empties", 32'(tx_empty), 1);
        enable = 1'b1;
        ncyc(40);
        chk(!busy && !rx_full, "R11 nothing sent after flush", {busy, rx_full}, 0);

        // R10 / R9: streaming two bytes, second byte overflows unread receive
        begin
            int cyc;
            clk_div = 8'd0; sample_end = 1'b0;
            preload(8'h9C, 1'b0, 1'b0);
            wr_en = 1'b1; wr_data = 8'hD2;
            @(negedge clk);
            wr_en = 1'b0;
            @(negedge clk);
            wr_en = 1'b1; wr_data = 8'h4E;
            cyc = 1;
            @(negedge clk);
            wr_en = 1'b0;
            while (busy && cyc < 10000) begin
                cyc++;
                @(negedge clk);
            end
            chk(cyc == 32, "R10 gapless stream", cyc, 32);
            chk(mcap == 16'hD24E, "R5 stream bit order", mcap, 16'hD24E);
            chk(rx_ovf == 1'b1, "R9 overflow set", 32'(rx_ovf), 1);
            chk(rd_data == 8'h9C, "R9 old byte kept", rd_data, 8'h9C);
            ncyc(5);
            chk(rx_ovf == 1'b1, "R9 overflow sticky", 32'(rx_ovf), 1);
        end

        // R12: interrupt masking (rx_full=1, tx_empty=1, ovf=1, done=1, busy=0)
        irq_en = 4'b0000;
        @(negedge clk);
        chk(irq == 1'b0, "R12 all masked", 32'(irq), 0);
        irq_en = 4'b0010;
        @(negedge clk);
        chk(irq == 1'b1, "R12 rx_full enabled", 32'(irq), 1);
        ovf_clr = 1'b1; rd_en = 1'b1; done_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0; rd_en = 1'b0; done_clr = 1'b0;
        chk(!rx_ovf && !rx_full, "R9 ovf clear", {rx_ovf, rx_full}, 0);
        irq_en = 4'b1110;
        @(negedge clk);
        chk(irq == 1'b0, "R12 cleared flags quiet", 32'(irq), 0);
        irq_en = 4'b0001;
        @(negedge clk);
        chk(irq == 1'b1, "R12 tx_empty enabled", 32'(irq), 1);
        irq_en = 4'b0000;

        // R3: disable mid-byte with a queued byte
        clk_div = 8'd1;
        preload(8'h00, 1'b0, 1'b0);
        wr_en = 1'b1; wr_data = 8'hA1;
        @(negedge clk);
        wr_en = 1'b0;
        ncyc(6);
        wr_en = 1'b1; wr_data = 8'h1A;
        @(negedge clk);
        wr_en = 1'b0;
        enable = 1'b0;
        @(negedge clk);
        chk(!busy && !sclk && !tx_empty, "R3 mid-byte disable", {busy, sclk, tx_empty}, 0);
        ncyc(10);
        chk(!busy && !sclk, "R3 stays stopped", {busy, sclk}, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule